// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block stands in for a keyboard attached to one receive channel of a serial controller. The host's transmitted characters reach it as command bytes. Key events arrive already translated, as a 7-bit keycode with a press or release flag. Every byte the keyboard would send back, whether a command answer or a key report, goes into a small circular queue. The controller's receive path reads that queue one byte at a time.

Three commands are recognised: a reset, a layout request and an LED command. The reset and the layout request each flush the queue and then write a fixed answer. The LED command makes the next command byte an argument that is swallowed. Caps-lock and num-lock events pass through a filter that lets only half of them through. This matches keyboards that report lock keys as toggles.

While a multi-byte answer is being written, one byte per cycle, the block holds further input off through `in_ready`. Each byte written to the queue raises a one-cycle `rx_notify` pulse to the receive logic. So does each read that leaves bytes behind.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset the following hold: `in_ready` is 1, `rx_avail` is 0, `rd_data` is 0 and `rx_notify` is 0.
- R2: Command 0x01 is accepted on a cycle where `cmd_valid` and `in_ready` are both high and no LED argument is pending. It empties the queue on the accepting edge. On the next three edges it writes 0xFF, 0x04 and 0x7F, in that order.
- R3: Command 0x07 and command 0x0F each empty the queue on the accepting edge. On the next two edges each writes 0xFE and then 0x21.
- R4: An accepted command 0x0E writes nothing. The next accepted command byte, whatever its value, is consumed silently and leaves the queue unchanged. Command bytes after that are decoded normally.
- R5: Any other command byte leaves the queue and `in_ready` unchanged.
- R6: A non-lock key event writes one byte. A press writes the keycode with bit 7 clear. A release writes the keycode with bit 7 set.
- R7: Caps-lock events (`key_caps`=1) use a 2-bit mode that starts at 0. A press inverts bit 0 and a release inverts bit 1. The event is dropped when the new mode is 2 after a press, or 3 after a release. Otherwise it is written as in R6.
- R8: Num-lock events (`key_num`=1, `key_caps`=0) follow the rule of R7 with their own mode, independent of the caps-lock mode. Other keys never change either mode.
- R9: The queue holds DEPTH bytes in order, and its pointers wrap around. A write attempted while the queue is full is dropped and raises no `rx_notify`.
- R10: `rd_data` shows the oldest queued byte, or 0 when the queue is empty. A `rd_strobe` pulse removes that byte. A strobe on an empty queue changes nothing.
- R11: `rx_notify` pulses for one cycle after each edge that writes a byte. It also pulses after each read that leaves at least one byte in the queue.
- R12: `in_ready` is low from the edge that accepts a reset or layout command until the last answer byte is written. Command and key strobes given while it is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a host command byte |
| cmd_byte | input | 8 | Host command byte |
| key_valid | input | 1 | One-cycle strobe for a key event |
| key_code | input | 7 | Translated keycode |
| key_press | input | 1 | 1 for a press, 0 for a release |
| key_caps | input | 1 | Event belongs to the caps-lock key |
| key_num | input | 1 | Event belongs to the num-lock key |
| in_ready | output | 1 | Command and key strobes are accepted |
| rd_strobe | input | 1 | Removes the byte shown on rd_data |
| rd_data | output | 8 | Oldest queued byte, 0 when empty |
| rx_avail | output | 1 | Queue is not empty |
| rx_notify | output | 1 | One-cycle receive-available pulse |

## Verification
The bench builds the block with DEPTH=4. With that depth, five key events are enough to fill the queue, see a write dropped and wrap both pointers. A 3-byte reset answer nearly fills the queue as well. The lock-key cases walk each mode through its full four-state cycle, with plain keys interleaved between them. A key strobe is placed inside a reset answer, to show that input is held off and that the answer order is kept.

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       key_valid,
  input  logic [6:0] key_code,
  input  logic       key_press,
  input  logic       key_caps,
  input  logic       key_num,
  output logic       in_ready,
  input  logic       rd_strobe,
  output logic [7:0] rd_data,
  output logic       rx_avail,
  output logic       rx_notify
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          busy, rsp_layout, led_mode;
  logic [1:0]    rsp_idx, caps_m, num_m;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready = !busy;

  logic cmd_take, key_take, is_reset, is_layout, is_led, flush;
  assign cmd_take  = cmd_valid && in_ready;
  assign key_take  = key_valid && in_ready && !cmd_take;
  assign is_reset  = cmd_byte == 8'h01;
  assign is_layout = cmd_byte == 8'h07 || cmd_byte == 8'h0F;
  assign is_led    = cmd_byte == 8'h0E;
  assign flush     = cmd_take && !led_mode && (is_reset || is_layout);

  logic [1:0] caps_nx, num_nx;
  logic       drop;
  assign caps_nx = key_press ? (caps_m ^ 2'b01) : (caps_m ^ 2'b10);
  assign num_nx  = key_press ? (num_m ^ 2'b01) : (num_m ^ 2'b10);
  always_comb begin
    if (key_caps)     drop = key_press ? (caps_nx == 2'd2) : (caps_nx == 2'd3);
    else if (key_num) drop = key_press ? (num_nx == 2'd2) : (num_nx == 2'd3);
    else              drop = 1'b0;
  end

  logic [7:0] rsp_byte;
  logic       rsp_last;
  always_comb begin
    case ({rsp_layout, rsp_idx})
      3'b000:  rsp_byte = 8'hFF;
      3'b001:  rsp_byte = 8'h04;
      3'b010:  rsp_byte = 8'h7F;
      3'b100:  rsp_byte = 8'hFE;
      3'b101:  rsp_byte = 8'h21;
      default: rsp_byte = 8'h00;
    endcase
  end
  assign rsp_last = rsp_layout ? (rsp_idx == 2'd1) : (rsp_idx == 2'd2);

  logic       push_ok, pop, full;
  logic [7:0] push_byte;
  assign full      = count == CW'(DEPTH);
  assign push_ok   = (busy || (key_take && !drop)) && !full && !flush;
  assign push_byte = busy ? rsp_byte : {!key_press, key_code};
  assign pop       = rd_strobe && rx_avail && !flush;

  assign rx_avail = count != '0;
  assign rd_data  = rx_avail ? mem[rptr] : 8'h00;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      count <= '0;
      rx_notify <= 1'b0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      count <= '0;
      rx_notify <= 1'b0;
    end else begin
      if (push_ok) wptr <= ptr_inc(wptr);
      if (pop) rptr <= ptr_inc(rptr);
      count <= count + CW'(push_ok) - CW'(pop);
      rx_notify <= push_ok || (pop && count > CW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rsp_layout <= 1'b0;
      rsp_idx <= '0;
      led_mode <= 1'b0;
      caps_m <= '0;
      num_m <= '0;
    end else begin
      if (flush) begin
        busy <= 1'b1;
        rsp_layout <= is_layout;
        rsp_idx <= '0;
      end else if (busy) begin
        rsp_idx <= rsp_idx + 1'b1;
        if (rsp_last) busy <= 1'b0;
      end
      if (cmd_take) led_mode <= led_mode ? 1'b0 : is_led;
      if (key_take && key_caps) caps_m <= caps_nx;
      else if (key_take && key_num) num_m <= num_nx;
    end
  end
endmodule

// File: rtl/kbd_cmd_responder_chk.sv
module kbd_cmd_responder_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic [7:0]                 cmd_byte,
  input logic                       key_valid,
  input logic                       in_ready,
  input logic                       rd_strobe,
  input logic                       rx_avail,
  input logic                       rx_notify,
  input logic                       led_mode,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CW = $clog2(DEPTH + 1);

  p_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && in_ready && !led_mode &&
     (cmd_byte == 8'h01 || cmd_byte == 8'h07 || cmd_byte == 8'h0F))
    |=> (!rx_avail && !in_ready));

  p_led_arg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && in_ready && led_mode) |=> (!led_mode && in_ready));

  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !rd_strobe && !cmd_valid) |=> (count == CW'(DEPTH)));

  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rx_avail && in_ready && !key_valid) |=> !rx_avail);

  p_notify_avail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_notify |-> rx_avail);
endmodule

bind kbd_cmd_responder kbd_cmd_responder_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .key_valid(key_valid), .in_ready(in_ready), .rd_strobe(rd_strobe),
  .rx_avail(rx_avail), .rx_notify(rx_notify), .led_mode(led_mode),
  .count(count)
);

// File: tb/kbd_cmd_responder_tb_top.sv
module kbd_cmd_responder_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, key_valid = 0, key_press = 0, key_caps = 0, key_num = 0, rd_strobe = 0;
  logic [7:0] cmd_byte = 0;
  logic [6:0] key_code = 0;
  logic in_ready, rx_avail, rx_notify;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  kbd_cmd_responder #(.DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .key_valid(key_valid), .key_code(key_code), .key_press(key_press),
    .key_caps(key_caps), .key_num(key_num), .in_ready(in_ready),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_avail(rx_avail),
    .rx_notify(rx_notify));

  // code, press, caps, num, emit, expected byte
  localparam logic [18:0] KEYV [12] = '{
    {7'h1C, 1'b1, 1'b0, 1'b0, 1'b1, 8'h1C},
    {7'h1C, 1'b0, 1'b0, 1'b0, 1'b1, 8'h9C},
    {7'h77, 1'b1, 1'b1, 1'b0, 1'b1, 8'h77},
    {7'h77, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {7'h77, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    {7'h77, 1'b0, 1'b1, 1'b0, 1'b1, 8'hF7},
    {7'h62, 1'b1, 1'b0, 1'b1, 1'b1, 8'h62},
    {7'h62, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {7'h05, 1'b1, 1'b0, 1'b0, 1'b1, 8'h05},
    {7'h62, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {7'h62, 1'b0, 1'b0, 1'b1, 1'b1, 8'hE2},
    {7'h7F, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    cmd_valid = 1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic send_key(input logic [6:0] c, input logic p, input logic cp, input logic nm);
    key_valid = 1; key_code = c; key_press = p; key_caps = cp; key_num = nm;
    @(negedge clk);
    key_valid = 0; key_caps = 0; key_num = 0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input logic exp_ntf, input string tag);
    chk({tag, " avail"}, rx_avail, 1);
    chk({tag, " data"}, rd_data, exp);
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
    chk({tag, " notify after read"}, rx_notify, exp_ntf);
  endtask

  task automatic wait_ready();
    while (!in_ready) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 rx_avail", rx_avail, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 rx_notify", rx_notify, 0);

    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
    chk("R10 empty read data", rd_data, 0);
    chk("R10 empty read avail", rx_avail, 0);
    chk("R10 empty read notify", rx_notify, 0);

    for (int i = 0; i < 12; i++) begin
      send_key(KEYV[i][18:12], KEYV[i][11], KEYV[i][10], KEYV[i][9]);
      if (KEYV[i][8]) begin
        chk($sformatf("R11 notify key %0d", i), rx_notify, 1);
        pop_chk(KEYV[i][7:0], 0, $sformatf("R6/R7/R8 key %0d", i));
        chk($sformatf("R6 empty after key %0d", i), rx_avail, 0);
      end else begin
        chk($sformatf("R7/R8 dropped key %0d", i), rx_avail, 0);
        chk($sformatf("R7/R8 no notify key %0d", i), rx_notify, 0);
      end
    end

    send_key(7'h11, 1, 0, 0);
    send_key(7'h12, 1, 0, 0);
    send_cmd(8'h01);
    chk("R2 flushed", rx_avail, 0);
    chk("R12 busy", in_ready, 0);
    send_key(7'h33, 1, 0, 0);
    wait_ready();
    pop_chk(8'hFF, 1, "R2 byte0");
    pop_chk(8'h04, 1, "R2 byte1");
    pop_chk(8'h7F, 0, "R2 byte2");
    chk("R12 key during answer ignored", rx_avail, 0);

    send_key(7'h44, 1, 0, 0);
    send_cmd(8'h07);
    chk("R3 flush 07", rx_avail, 0);
    wait_ready();
    pop_chk(8'hFE, 1, "R3 07 byte0");
    pop_chk(8'h21, 0, "R3 07 byte1");
    send_cmd(8'h0F);
    wait_ready();
    pop_chk(8'hFE, 1, "R3 0F byte0");
    pop_chk(8'h21, 0, "R3 0F byte1");
    chk("R3 empty", rx_avail, 0);

    send_key(7'h2A, 1, 0, 0);
    send_cmd(8'h0E);
    chk("R4 led no answer ready", in_ready, 1);
    send_cmd(8'h01);
    chk("R4 arg consumed ready", in_ready, 1);
    pop_chk(8'h2A, 0, "R4 queue kept");
    chk("R4 empty", rx_avail, 0);
    send_cmd(8'h0F);
    wait_ready();
    pop_chk(8'hFE, 1, "R4 decode resumes");
    pop_chk(8'h21, 0, "R4 decode resumes");

    send_key(7'h40, 1, 0, 0);
    send_cmd(8'h55);
    chk("R5 ready", in_ready, 1);
    send_cmd(8'h00);
    pop_chk(8'h40, 0, "R5 queue kept");
    chk("R5 empty", rx_avail, 0);

    for (int i = 1; i <= 5; i++) begin
      send_key(7'(i), 1, 0, 0);
      chk($sformatf("R9 notify push %0d", i), rx_notify, i <= 4);
    end
    pop_chk(8'h01, 1, "R9 fifo0");
    pop_chk(8'h02, 1, "R9 fifo1");
    pop_chk(8'h03, 1, "R9 fifo2");
    pop_chk(8'h04, 0, "R9 fifo3");
    chk("R9 fifth dropped", rx_avail, 0);
    chk("R10 empty data", rd_data, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule